// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Controller

This block is the slave end of a two-wire serial EEPROM. It oversamples the clock and data lines with the system clock and finds Start, repeated Start and Stop events on them. It then takes in a select byte and answers it only when the byte names the memory device type and the strap code set on three chip-enable pins. After that it serves reads and writes against an internal byte array.

Reads come in three kinds. A read can continue from the internal address counter, it can follow an address phase and a repeated Start, or it can run on for as long as the master acknowledges each byte. Writes are collected into a page buffer and land in the array only when the transfer ends with a Stop. A write-protect pin refuses data bytes.

The data line is open-drain. The block only ever pulls it low, through an output enable. The array holds 2^`MEM_AW` bytes. The default is 2 KiB, and `MEM_AW`=13 gives the full 8 KiB map.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: While reset is held, and after it is released, the block does not drive the data line until it is addressed.
- R2: After a Start, a select byte received MSB first whose bits [7:4] are 1010 and whose bits [3:1] equal `ce_i` is acknowledged: the data line is held low through the ninth clock. Bit 0 gives the direction, with 1 for read and 0 for write.
- R3: A select byte with the wrong type or the wrong chip-enable code gets no acknowledge. The block then ignores the bus, leaving later bytes unacknowledged, until the next Start.
- R4: A write select is followed by an address high byte and an address low byte, each acknowledged. A data byte sent after them with `wc_i` low is acknowledged, and it can be read back after the Stop.
- R5: A random read is made of an address phase, a repeated Start and a read select, and it returns the byte at that address. Address bits above `MEM_AW` are ignored.
- R6: A read select given without an address phase returns the byte at the internal counter. The counter holds the last accessed address plus one.
- R7: The counter increments after every byte read. During a sequential read it wraps from the last location to 0.
- R8: A page write accepts successive data bytes into one 32-byte page. The low five address bits wrap inside the page, so that a later byte replaces an earlier one in the same slot.
- R9: Written data reaches the array only on a Stop. Bytes still pending when a repeated Start arrives are dropped.
- R10: While `wc_i` is high, the select and address bytes are still acknowledged, but data bytes are not, and the array keeps its contents.
- R11: A master NACK after a read byte ends the read. The block releases the data line and does not drive it again before a new Start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull the data line low when 1 |
| ce_i | input | 3 | Chip-enable strap code |
| wc_i | input | 1 | Write protect; 1 blocks data writes |

## Verification
Two things land in one system-clock cycle on the falling clock edge that ends a write data byte. The byte is stored into its page-buffer slot, and the page-local counter steps on and may wrap to slot 0. The bench provokes this with a page write of 34 bytes that starts five bytes into a page. It then reads the whole page back and compares each location against a model built from the requirement. The read counter wrap coincides with the fetch of the following byte in the same way. A sequential read that starts at the top location must return location 0 as its second byte.

// File: rtl/i2c_ee_pkg.sv
`timescale 1ns/1ps
package i2c_ee_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_ACK_DEV,
        ST_ADDR_HI,
        ST_ACK_HI,
        ST_ADDR_LO,
        ST_ACK_LO,
        ST_WDATA,
        ST_ACK_W,
        ST_RDATA,
        ST_RACK,
        ST_COMMIT
    } ee_state_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/i2c_ee_sync.sv
`timescale 1ns/1ps
module i2c_ee_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] level_o,
    output logic [LINES-1:0] rise_o,
    output logic [LINES-1:0] fall_o
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // pipe_q[STAGES-1] is the synchronised level, pipe_q[STAGES] its history
        logic [STAGES:0] pipe_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= {pipe_q[STAGES-1:0], raw_i[g]};
        end

        assign level_o[g] = pipe_q[STAGES-1];
        assign rise_o[g]  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
        assign fall_o[g]  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
    end

endmodule

// File: rtl/i2c_ee_mem.sv
`timescale 1ns/1ps
module i2c_ee_mem #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) cells[waddr_i] <= wdata_i;
    end

    assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/i2c_eeprom_slave.sv
`timescale 1ns/1ps
module i2c_eeprom_slave
    import i2c_ee_pkg::*;
#(
    parameter int MEM_AW      = 11,
    parameter int PAGE_BYTES  = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] ce_i,
    input  logic       wc_i
);

    localparam int PAGE_AW = $clog2(PAGE_BYTES);
    localparam logic [PAGE_AW-1:0] LAST_SLOT = PAGE_AW'(PAGE_BYTES - 1);

    typedef struct packed {
        ee_state_e                   state;
        logic [3:0]                  bitcnt;
        logic [7:0]                  sh;
        logic                        rw;
        logic                        mack;
        logic                        oe;
        logic [MEM_AW-1:0]           addr;
        logic [PAGE_BYTES-1:0][7:0]  pbuf;
        logic [PAGE_BYTES-1:0]       pvld;
        logic [PAGE_AW-1:0]          cidx;
    } ctl_t;

    ctl_t q, d;

    logic       scl_lvl, sda_lvl, scl_rise, scl_fall, sda_rise, sda_fall;
    logic [1:0] lvl_w, rise_w, fall_w;
    logic       start_ev, stop_ev;
    logic       mem_we;
    logic [MEM_AW-1:0] mem_waddr;
    logic [7:0] mem_wdata, mem_rdata;
    logic       dev_match;

    i2c_ee_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i({scl_i, sda_i}),
        .level_o(lvl_w), .rise_o(rise_w), .fall_o(fall_w)
    );

    assign {scl_lvl, sda_lvl}   = lvl_w;
    assign {scl_rise, sda_rise} = rise_w;
    assign {scl_fall, sda_fall} = fall_w;
    assign start_ev = sda_fall & scl_lvl;
    assign stop_ev  = sda_rise & scl_lvl;

    // page buffer drains one slot per cycle once a Stop has been seen
    assign mem_we    = (q.state == ST_COMMIT) && q.pvld[q.cidx];
    assign mem_waddr = {q.addr[MEM_AW-1:PAGE_AW], q.cidx};
    assign mem_wdata = q.pbuf[q.cidx];

    i2c_ee_mem #(.AW(MEM_AW), .DW(8)) u_mem (
        .clk(clk), .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(mem_wdata),
        .raddr_i(q.addr), .rdata_o(mem_rdata)
    );

    assign dev_match = (q.sh[7:4] == DEV_TYPE) && (q.sh[3:1] == ce_i);

    always_comb begin
        d = q;
        if (q.state == ST_COMMIT) begin
            d.cidx = q.cidx + PAGE_AW'(1);
            if (q.cidx == LAST_SLOT) begin
                d.state = ST_IDLE;
                d.pvld  = '0;
            end
        end else if (start_ev) begin
            d.state  = ST_DEVSEL;
            d.bitcnt = '0;
            d.oe     = 1'b0;
            d.pvld   = '0;
        end else if (stop_ev) begin
            d.oe = 1'b0;
            if (|q.pvld) begin
                d.state = ST_COMMIT;
                d.cidx  = '0;
            end else begin
                d.state = ST_IDLE;
            end
        end else begin
            unique case (q.state)
                ST_DEVSEL, ST_ADDR_HI, ST_ADDR_LO, ST_WDATA: begin
                    if (scl_rise) begin
                        d.sh     = {q.sh[6:0], sda_lvl};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && q.bitcnt == 4'd8) begin
                        d.bitcnt = '0;
                        if (q.state == ST_DEVSEL) begin
                            if (dev_match) begin
                                d.rw    = q.sh[0];
                                d.state = ST_ACK_DEV;
                                d.oe    = 1'b1;
                            end else begin
                                d.state = ST_IDLE;
                            end
                        end else if (q.state == ST_ADDR_HI) begin
                            d.addr  = {q.sh[MEM_AW-9:0], q.addr[7:0]};
                            d.state = ST_ACK_HI;
                            d.oe    = 1'b1;
                        end else if (q.state == ST_ADDR_LO) begin
                            d.addr  = {q.addr[MEM_AW-1:8], q.sh};
                            d.state = ST_ACK_LO;
                            d.oe    = 1'b1;
                        end else begin
                            d.state = ST_ACK_W;
                            if (!wc_i) begin
                                d.pbuf[q.addr[PAGE_AW-1:0]] = q.sh;
                                d.pvld[q.addr[PAGE_AW-1:0]] = 1'b1;
                                d.addr = {q.addr[MEM_AW-1:PAGE_AW],
                                          q.addr[PAGE_AW-1:0] + PAGE_AW'(1)};
                                d.oe   = 1'b1;
                            end
                        end
                    end
                end
                ST_ACK_DEV, ST_ACK_HI, ST_ACK_LO, ST_ACK_W: begin
                    if (scl_fall) begin
                        d.oe     = 1'b0;
                        d.bitcnt = '0;
                        if (q.state == ST_ACK_HI)      d.state = ST_ADDR_LO;
                        else if (q.state == ST_ACK_LO) d.state = ST_WDATA;
                        else if (q.state == ST_ACK_W)  d.state = ST_WDATA;
                        else if (q.rw) begin
                            d.state = ST_RDATA;
                            d.sh    = mem_rdata;
                            d.oe    = ~mem_rdata[7];
                        end else begin
                            d.state = ST_ADDR_HI;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (q.bitcnt == 4'd7) begin
                            d.state  = ST_RACK;
                            d.oe     = 1'b0;
                            d.bitcnt = '0;
                            d.addr   = q.addr + MEM_AW'(1);
                        end else begin
                            d.bitcnt = q.bitcnt + 4'd1;
                            d.sh     = {q.sh[6:0], 1'b0};
                            d.oe     = ~q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.state  = ST_RDATA;
                            d.sh     = mem_rdata;
                            d.oe     = ~mem_rdata[7];
                            d.bitcnt = '0;
                        end else begin
                            d.state = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe_o = q.oe;

endmodule

// File: rtl/i2c_ee_chk.sv
`timescale 1ns/1ps
module i2c_ee_chk
    import i2c_ee_pkg::*;
#(
    parameter int MEM_AW = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe_o,
    input logic              wc_i,
    input logic              scl_fall,
    input logic              start_ev,
    input logic              stop_ev,
    input ee_state_e         state_q,
    input logic [3:0]        bitcnt_q,
    input logic [7:0]        sh_q,
    input logic [MEM_AW-1:0] addr_q
);

    AST_OE_MOVES_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> ($past(scl_fall) || $past(start_ev) || $past(stop_ev))) // R2
        else $error("data drive changed away from a clock fall");

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_oe_o) // R1
        else $error("data line driven in standby");

    AST_WRONG_TYPE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEVSEL && scl_fall && bitcnt_q == 4'd8 && sh_q[7:4] != 4'b1010)
        |=> (state_q == ST_IDLE)) // R3
        else $error("wrong device type not rejected");

    AST_WC_NO_DATA_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WDATA && scl_fall && bitcnt_q == 4'd8 && wc_i) |=> !sda_oe_o) // R10
        else $error("data byte acknowledged while write protected");

    AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_COMMIT) |-> $past(stop_ev)) // R9
        else $error("array update began without a Stop");

    AST_READ_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RDATA && scl_fall && bitcnt_q == 4'd7)
        |=> (addr_q == $past(addr_q) + MEM_AW'(1))) // R7
        else $error("read counter did not step");

endmodule

bind i2c_eeprom_slave i2c_ee_chk #(.MEM_AW(MEM_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe_o(sda_oe_o), .wc_i(wc_i),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .state_q(q.state), .bitcnt_q(q.bitcnt), .sh_q(q.sh), .addr_q(q.addr)
);

// File: tb/tb_i2c_eeprom_slave.sv
`timescale 1ns/1ps
module tb_i2c_eeprom_slave;

    localparam int Q     = 10;       // system clocks per quarter bus bit
    localparam int WDOG  = 150000;
    localparam logic [2:0] CE    = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, CE, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, CE, 1'b1};

    // {write address, read address, data}
    localparam logic [39:0] VEC [6] = '{
        {16'h0010, 16'hF810, 8'hA5},
        {16'h0123, 16'h0123, 8'h3C},
        {16'h07FE, 16'h07FE, 8'h81},
        {16'h0400, 16'h0400, 8'h00},
        {16'h0255, 16'h0255, 8'hFF},
        {16'h0031, 16'h1831, 8'h6E}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic wc = 1'b0;
    logic dut_oe;
    logic sda_line;
    int   checks = 0;
    int   errors = 0;

    always #2.5 clk = ~clk;

    assign sda_line = ~(m_low | dut_oe);

    i2c_eeprom_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe_o(dut_oe), .ce_i(CE), .wc_i(wc)
    );

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; hq();
        m_scl = 1'b1; hq();
        m_low = 1'b1; hq();
        m_scl = 1'b0; hq();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; hq();
        m_scl = 1'b1; hq();
        m_low = 1'b0; hq();
        repeat (60) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; hq();
            m_scl = 1'b1; hq(); hq();
            m_scl = 1'b0; hq();
        end
        m_low = 1'b0; hq();
        m_scl = 1'b1; hq();
        acked = (sda_line == 1'b0);
        hq();
        m_scl = 1'b0; hq();
    endtask

    task automatic recv_byte(input logic ack_it, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            hq();
            m_scl = 1'b1; hq();
            b[i] = sda_line;
            hq();
            m_scl = 1'b0; hq();
        end
        m_low = ack_it; hq();
        m_scl = 1'b1; hq(); hq();
        m_scl = 1'b0; hq();
        m_low = 1'b0;
    endtask

    task automatic byte_write(input logic [15:0] a, input logic [7:0] v, input logic exp_dack);
        logic ak;
        bus_start();
        send_byte(DEV_W, ak);  check_eq("R2 write select ack", ak, 1);
        send_byte(a[15:8], ak); check_eq("R4 address high ack", ak, 1);
        send_byte(a[7:0], ak);  check_eq("R4 address low ack", ak, 1);
        send_byte(v, ak);
        check_eq(exp_dack ? "R4 data ack" : "R10 data nack while protected", ak, exp_dack);
        bus_stop();
    endtask

    task automatic read_setup(input logic [15:0] a);
        logic ak;
        bus_start();
        send_byte(DEV_W, ak);   check_eq("R2 write select ack", ak, 1);
        send_byte(a[15:8], ak); check_eq("R5 address high ack", ak, 1);
        send_byte(a[7:0], ak);  check_eq("R5 address low ack", ak, 1);
        bus_start();
        send_byte(DEV_R, ak);   check_eq("R2 read select ack", ak, 1);
    endtask

    task automatic read_one(input logic [15:0] a, output logic [7:0] v);
        read_setup(a);
        recv_byte(1'b0, v);
        bus_stop();
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v, v2;
        logic       ak;
        logic [7:0] page_exp [32];

        // R1: quiet during and after reset
        repeat (5) @(negedge clk);
        check_eq("R1 no drive in reset", dut_oe, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check_eq("R1 no drive after reset", dut_oe, 0);

        // table walk: R4 byte write then R5 random read (with ignored upper bits)
        for (int k = 0; k < 6; k++) begin
            byte_write(VEC[k][39:24], VEC[k][7:0], 1'b1);
            read_one(VEC[k][23:8], v);
            check_eq("R5 random read data", v, VEC[k][7:0]);
        end

        // R8: page write of 34 bytes starting at slot 5, wraps inside the page
        byte_write(16'h0120, 8'h5A, 1'b1);
        bus_start();
        send_byte(DEV_W, ak);  check_eq("R2 write select ack", ak, 1);
        send_byte(8'h01, ak);  check_eq("R8 address high ack", ak, 1);
        send_byte(8'h05, ak);  check_eq("R8 address low ack", ak, 1);
        for (int i = 0; i < 34; i++) begin
            send_byte(8'h40 + 8'(i), ak);
            check_eq("R8 page data ack", ak, 1);
            page_exp[(5 + i) % 32] = 8'h40 + 8'(i);
        end
        bus_stop();
        read_setup(16'h0100);
        for (int i = 0; i < 32; i++) begin
            recv_byte(i != 31, v);
            check_eq("R8 page readback", v, page_exp[i]);
        end
        bus_stop();

        // R6: counter now sits just past the page
        bus_start();
        send_byte(DEV_R, ak);  check_eq("R2 read select ack", ak, 1);
        recv_byte(1'b0, v);
        bus_stop();
        check_eq("R6 current address read", v, 8'h5A);

        // R7: sequential read wraps from top location to 0
        byte_write(16'h07FF, 8'hC3, 1'b1);
        byte_write(16'h0000, 8'h3C, 1'b1);
        read_setup(16'h07FF);
        recv_byte(1'b1, v);
        recv_byte(1'b0, v2);
        bus_stop();
        check_eq("R7 top location", v, 8'hC3);
        check_eq("R7 wrap to location 0", v2, 8'h3C);

        // R10: write protect refuses data but not select or address
        byte_write(16'h0200, 8'h11, 1'b1);
        wc = 1'b1;
        byte_write(16'h0200, 8'h99, 1'b0);
        wc = 1'b0;
        read_one(16'h0200, v);
        check_eq("R10 array unchanged", v, 8'h11);

        // R9: repeated Start drops pending write data
        byte_write(16'h0300, 8'h22, 1'b1);
        bus_start();
        send_byte(DEV_W, ak);
        send_byte(8'h03, ak);
        send_byte(8'h00, ak);
        send_byte(8'h77, ak); check_eq("R9 pending data ack", ak, 1);
        bus_start();
        send_byte(DEV_R, ak); check_eq("R2 read select ack", ak, 1);
        recv_byte(1'b0, v);
        bus_stop();
        read_one(16'h0300, v);
        check_eq("R9 no write without Stop", v, 8'h22);

        // R3: wrong chip enable, then wrong type
        bus_start();
        send_byte({4'b1010, 3'b100, 1'b0}, ak); check_eq("R3 wrong enable nack", ak, 0);
        send_byte(8'h00, ak);                   check_eq("R3 standby byte nack", ak, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, CE, 1'b0}, ak);     check_eq("R3 wrong type nack", ak, 0);
        bus_stop();

        // R11: after master NACK the line stays released
        read_setup(16'h0123);
        recv_byte(1'b0, v);
        check_eq("R11 read data", v, 8'h3C);
        recv_byte(1'b0, v2);
        check_eq("R11 line released after nack", v2, 8'hFF);
        bus_stop();

        // R1: mid-run reset leaves the line released
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R1 reset mid-run", dut_oe, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule